// File: doc/BRIEF.md
# Pixel Burst Capture Source with SPI Slave Port

This block sits on the sensor side of a serial link. It serves a one-time dump of raw pixel data to a host. The host talks to it as an SPI slave. A register write arms a capture. From that point the block takes pixels from a frame-source stream: 6-bit pixel beats, with a strobe that marks the first pixel of each frame. It stores the next complete frame and then a fixed number of pixels from the frame after it. Once the store is complete, one ordinary read of the burst register starts a stream out of the port. The stream carries one byte for each group of eight SCLK periods and lasts while NCS stays low. No further address is sent during the stream.

Each streamed byte has its top bit forced high. Bit 6 carries a start-of-frame marker, and the low six bits carry the pixel. Reads made before the store is complete return zeros. Reads past the end of the stored data also return zeros. Once armed, a navigation-off flag stays high until hardware reset.

All SPI inputs are sampled in the block's own clock through synchronizers. For this reason, each SCLK half period must last at least four clock cycles. The pixel input uses valid/ready. A beat transfers on a clock where both are high. `pix_ready` goes high one cycle after reset and stays high, so the block never applies back-pressure. Beats that arrive while no capture is filling are consumed and dropped. A source must therefore not rely on stalling to keep a frame.

Top module: `pixel_burst_src`

## Requirements
- R1: Transactions use SPI mode 3. NCS is low, SCLK idles high, MOSI is sampled on the rising edge and MISO changes after the falling edge, most significant bit first. The first byte is a command: bit 7 = 1 for a write followed by one data byte, bit 7 = 0 for a read. Bits 6:0 hold the address. MISO is 0 during every command byte and whenever NCS is high.
- R2: A write of any data to the capture address (default 0x12) arms a capture. The block then drops beats until a beat with `pix_sof` high. It stores that beat and the following beats, FULL_PIX + PART_PIX in total, in arrival order. Burst byte k (from 0) holds stored pixel k.
- R3: When the burst was decoded with a complete capture, every byte at an index below FULL_PIX + PART_PIX has bit 7 = 1 and bits 5:0 equal to the stored pixel.
- R4: Bit 6 of a streamed byte is 1 only at index 0 and at index FULL_PIX. It is 0 for all other bytes.
- R5: Bytes at index FULL_PIX + PART_PIX and above read 0x00.
- R6: A burst decoded while no complete capture exists returns 0x00 for every byte of that transaction. This holds even if the capture completes during the transaction.
- R7: Raising NCS ends a burst at any point. The next transaction starts with a command byte, and a new burst read starts again from index 0.
- R8: `nav_off` is 0 after reset. Arming a capture sets it, and only reset clears it.
- R9: A read of any address other than the burst address (default 0x40) returns 0x00. A write to any address other than the capture address changes neither the capture nor `nav_off`.
- R10: `pix_ready` is 1 at every cycle after reset. Beats arriving after the capture is complete do not change the stored data.
- R11: A new capture write that arrives while a fill is in progress takes priority over a pixel beat accepted in the same cycle. It discards the partial fill, and storing restarts at the next `pix_sof` beat.
- R12: After reset, MISO is 0, `nav_off` is 0, and no capture is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | SPI serial clock, idles high |
| ncs | input | 1 | SPI select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| pix_valid | input | 1 | Pixel beat valid |
| pix_ready | output | 1 | Pixel beat ready, high after reset |
| pix_data | input | 6 | Pixel value |
| pix_sof | input | 1 | Beat is the first pixel of a frame |
| nav_off | output | 1 | Navigation disabled, sticky until reset |

## Verification
The capture command decode and an accepted pixel beat can fall in the same clock while a fill is running. The command must win, and that beat must not be stored. To provoke this, the bench arms a capture and starts a stream with a valid beat on every cycle. While the stream runs, it issues a second capture write, timed so that the write decodes inside the fill window. A beat is therefore present in the decode cycle. The result is judged by reading the full capture and checking it byte for byte against the frames sent after the stream. A design that ignored the rearm would return the interrupted frames instead.

// File: rtl/pixel_burst_pkg.sv
package pixel_burst_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;
  localparam int unsigned PIX_W  = BYTE_W - 2;

  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_WAIT,
    CAP_FILL,
    CAP_DONE
  } cap_state_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_WDATA,
    PH_RDATA,
    PH_BURST
  } spi_phase_e;
endpackage

// File: rtl/pbs_spi_port.sv
module pbs_spi_port
  import pixel_burst_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CAP_ADDR    = 7'h12,
  parameter logic [ADDR_W-1:0] BURST_ADDR  = 7'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              ncs,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] ld_byte,
  output logic              miso,
  output logic              arm,
  output logic              burst_go,
  output logic              byte_adv,
  output logic              ld_en,
  output logic              port_idle
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES:0]   sclk_sr;
  logic [SYNC_STAGES-1:0] ncs_sr;
  logic [SYNC_STAGES-1:0] mosi_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sr <= '1;
      ncs_sr  <= '1;
      mosi_sr <= '0;
    end else begin
      sclk_sr <= {sclk_sr[SYNC_STAGES-1:0], sclk};
      ncs_sr  <= {ncs_sr[SYNC_STAGES-2:0], ncs};
      mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
    end
  end

  logic sel, mosi_bit, sclk_rise, sclk_fall;
  assign sel       = ~ncs_sr[SYNC_STAGES-1];
  assign mosi_bit  = mosi_sr[SYNC_STAGES-1];
  assign sclk_rise = sclk_sr[SYNC_STAGES-1] & ~sclk_sr[SYNC_STAGES];
  assign sclk_fall = ~sclk_sr[SYNC_STAGES-1] & sclk_sr[SYNC_STAGES];

  spi_phase_e        phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shin, tx, rx_byte;
  logic [ADDR_W-1:0] addr_q;
  logic              pend, miso_q, byte_end;

  assign rx_byte  = {shin[BYTE_W-2:0], mosi_bit};
  assign byte_end = sel & sclk_rise & (bitcnt == LAST_BIT);

  assign arm      = byte_end && (phase == PH_WDATA) && (addr_q == CAP_ADDR);
  assign burst_go = byte_end && (phase == PH_CMD) && !rx_byte[BYTE_W-1]
                    && (rx_byte[ADDR_W-1:0] == BURST_ADDR);
  assign byte_adv = byte_end && (phase == PH_BURST);
  assign ld_en    = sel & sclk_fall & pend;
  assign port_idle = ~sel;
  assign miso     = miso_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (byte_end && phase == PH_CMD && rx_byte[BYTE_W-1]) begin
      addr_q <= rx_byte[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      phase  <= PH_CMD;
      bitcnt <= '0;
      shin   <= '0;
      tx     <= '0;
      miso_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (sclk_rise) begin
        shin   <= rx_byte;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == LAST_BIT) begin
          case (phase)
            PH_CMD: begin
              if (rx_byte[BYTE_W-1]) begin
                phase <= PH_WDATA;
              end else if (rx_byte[ADDR_W-1:0] == BURST_ADDR) begin
                phase <= PH_BURST;
                pend  <= 1'b1;
              end else begin
                phase <= PH_RDATA;
              end
            end
            PH_WDATA, PH_RDATA: phase <= PH_CMD;
            PH_BURST:           pend  <= 1'b1;
            default:            phase <= PH_CMD;
          endcase
        end
      end
      if (sclk_fall) begin
        if (pend) begin
          miso_q <= ld_byte[BYTE_W-1];
          tx     <= {ld_byte[BYTE_W-2:0], 1'b0};
          pend   <= 1'b0;
        end else begin
          miso_q <= tx[BYTE_W-1];
          tx     <= {tx[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/pbs_capture_ctrl.sv
module pbs_capture_ctrl
  import pixel_burst_pkg::*;
#(
  parameter int unsigned TOTAL = 1536,
  parameter int unsigned AW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          pix_valid,
  input  logic          pix_sof,
  output logic          pix_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          cap_ready,
  output logic          nav_off
);
  cap_state_e    state;
  logic [AW-1:0] wr_ptr;
  logic          ready_q, beat, take_first, take_more, last;

  assign pix_ready  = ready_q;
  assign beat       = pix_valid & ready_q;
  assign take_first = beat & pix_sof & (state == CAP_WAIT) & ~arm;
  assign take_more  = beat & (state == CAP_FILL) & ~arm;
  assign last       = (wr_ptr == AW'(TOTAL - 1));
  assign mem_we     = take_first | take_more;
  assign mem_waddr  = (state == CAP_WAIT) ? '0 : wr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CAP_IDLE;
      wr_ptr    <= '0;
      cap_ready <= 1'b0;
      nav_off   <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (arm) begin
        state     <= CAP_WAIT;
        wr_ptr    <= '0;
        cap_ready <= 1'b0;
        nav_off   <= 1'b1;
      end else if (take_first) begin
        state  <= CAP_FILL;
        wr_ptr <= AW'(1);
      end else if (take_more) begin
        if (last) begin
          state     <= CAP_DONE;
          cap_ready <= 1'b1;
        end else begin
          wr_ptr <= wr_ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pbs_pixel_ram.sv
module pbs_pixel_ram #(
  parameter int unsigned DEPTH = 1536,
  parameter int unsigned WIDTH = 6,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [AW-1:0]    raddr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    addr;

  assign addr = we ? waddr : raddr;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pbs_burst_fmt.sv
module pbs_burst_fmt
  import pixel_burst_pkg::*;
#(
  parameter int unsigned FULL  = 900,
  parameter int unsigned TOTAL = 1536,
  parameter int unsigned AW    = $clog2(TOTAL),
  parameter int unsigned IW    = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_go,
  input  logic              byte_adv,
  input  logic              cap_ready,
  input  logic [PIX_W-1:0]  rdata,
  output logic [AW-1:0]     raddr,
  output logic [IW-1:0]     ld_idx,
  output logic [BYTE_W-1:0] ld_byte
);
  logic [IW-1:0] idx;
  logic          ok, in_range, marker;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      ok  <= 1'b0;
    end else if (burst_go) begin
      idx <= '0;
      ok  <= cap_ready;
    end else if (byte_adv && idx != IW'(TOTAL)) begin
      idx <= idx + 1'b1;
    end
  end

  assign in_range = (idx < IW'(TOTAL));
  assign marker   = (idx == '0) || (idx == IW'(FULL));
  assign raddr    = idx[AW-1:0];
  assign ld_idx   = idx;
  assign ld_byte  = (ok && in_range) ? {1'b1, marker, rdata} : '0;
endmodule

// File: rtl/pixel_burst_src.sv
module pixel_burst_src
  import pixel_burst_pkg::*;
#(
  parameter int unsigned       FULL_PIX    = 900,
  parameter int unsigned       PART_PIX    = 636,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CAP_ADDR    = 7'h12,
  parameter logic [ADDR_W-1:0] BURST_ADDR  = 7'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             ncs,
  input  logic             mosi,
  output logic             miso,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_sof,
  output logic             nav_off
);
  localparam int unsigned TOTAL = FULL_PIX + PART_PIX;
  localparam int unsigned AW    = $clog2(TOTAL);
  localparam int unsigned IW    = $clog2(TOTAL + 1);

  logic              arm, burst_go, byte_adv, ld_en, port_idle;
  logic              mem_we, cap_ready;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [PIX_W-1:0]  mem_rdata;
  logic [IW-1:0]     ld_idx;
  logic [BYTE_W-1:0] ld_byte;

  pbs_spi_port #(
    .SYNC_STAGES(SYNC_STAGES),
    .CAP_ADDR   (CAP_ADDR),
    .BURST_ADDR (BURST_ADDR)
  ) u_port (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .ncs      (ncs),
    .mosi     (mosi),
    .ld_byte  (ld_byte),
    .miso     (miso),
    .arm      (arm),
    .burst_go (burst_go),
    .byte_adv (byte_adv),
    .ld_en    (ld_en),
    .port_idle(port_idle)
  );

  pbs_capture_ctrl #(
    .TOTAL(TOTAL),
    .AW   (AW)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .arm      (arm),
    .pix_valid(pix_valid),
    .pix_sof  (pix_sof),
    .pix_ready(pix_ready),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .cap_ready(cap_ready),
    .nav_off  (nav_off)
  );

  pbs_pixel_ram #(
    .DEPTH(TOTAL),
    .WIDTH(PIX_W),
    .AW   (AW)
  ) u_ram (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .raddr(mem_raddr),
    .wdata(pix_data),
    .rdata(mem_rdata)
  );

  pbs_burst_fmt #(
    .FULL (FULL_PIX),
    .TOTAL(TOTAL),
    .AW   (AW),
    .IW   (IW)
  ) u_fmt (
    .clk      (clk),
    .rst      (rst),
    .burst_go (burst_go),
    .byte_adv (byte_adv),
    .cap_ready(cap_ready),
    .rdata    (mem_rdata),
    .raddr    (mem_raddr),
    .ld_idx   (ld_idx),
    .ld_byte  (ld_byte)
  );
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
  parameter int unsigned FULL  = 900,
  parameter int unsigned TOTAL = 1536,
  parameter int unsigned IW    = $clog2(TOTAL + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          port_idle,
  input logic          miso,
  input logic          arm,
  input logic          nav_off,
  input logic          cap_ready,
  input logic          mem_we,
  input logic          ld_en,
  input logic [7:0]    ld_byte,
  input logic [IW-1:0] ld_idx
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    port_idle |=> !miso);

  p_arm_clears_ready_r2: assert property (@(posedge clk) disable iff (rst)
    arm |=> !cap_ready);

  p_ready_after_write_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_ready) |-> $past(mem_we));

  p_msb_high_r3: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_byte != 8'h00) |-> ld_byte[7]);

  p_marker_pos_r4: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_byte[6]) |-> (ld_idx == '0 || ld_idx == IW'(FULL)));

  p_zero_tail_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_idx >= IW'(TOTAL)) |-> (ld_byte == 8'h00));

  p_nav_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    nav_off |=> nav_off);

  p_arm_sets_nav_r8: assert property (@(posedge clk) disable iff (rst)
    arm |=> nav_off);

  p_no_write_when_done_r10: assert property (@(posedge clk) disable iff (rst)
    cap_ready |-> !mem_we);
endmodule

bind pixel_burst_src pbs_chk #(
  .FULL (FULL_PIX),
  .TOTAL(TOTAL),
  .IW   (IW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .port_idle(port_idle),
  .miso     (miso),
  .arm      (arm),
  .nav_off  (nav_off),
  .cap_ready(cap_ready),
  .mem_we   (mem_we),
  .ld_en    (ld_en),
  .ld_byte  (ld_byte),
  .ld_idx   (ld_idx)
);

// File: tb/sim_pixel_burst_src.sv
module sim_pixel_burst_src;
  localparam int FULL  = 90;
  localparam int PART  = 60;
  localparam int TOTAL = FULL + PART;
  localparam int NB    = TOTAL + 2;
  localparam int HALF  = 4;
  localparam logic [6:0] CAP   = 7'h12;
  localparam logic [6:0] BURST = 7'h40;
  localparam logic [6:0] OTHER = 7'h05;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b1, ncs = 1'b1, mosi = 1'b0;
  logic pix_valid = 1'b0, pix_sof = 1'b0;
  logic [5:0] pix_data = '0;
  logic miso, pix_ready, nav_off;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] got [NB];
  logic [7:0] cmd_rx;

  always #2 clk = ~clk;

  pixel_burst_src #(
    .FULL_PIX  (FULL),
    .PART_PIX  (PART),
    .CAP_ADDR  (CAP),
    .BURST_ADDR(BURST)
  ) u0 (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .ncs      (ncs),
    .mosi     (mosi),
    .miso     (miso),
    .pix_valid(pix_valid),
    .pix_ready(pix_ready),
    .pix_data (pix_data),
    .pix_sof  (pix_sof),
    .nav_off  (nav_off)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] pix(input int f, input int i);
    return 6'((f * 11 + i * 3 + 1) % 64);
  endfunction

  function automatic logic [7:0] expb(input int f, input int k);
    if (k < FULL)       return {1'b1, k == 0, pix(f, k)};
    else if (k < TOTAL) return {1'b1, k == FULL, pix(f + 1, k - FULL)};
    else                return 8'h00;
  endfunction

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      sclk = 1'b0;
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic spi_begin();
    @(negedge clk);
    ncs = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_end();
    ncs = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic spi_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    spi_begin();
    spi_byte({1'b1, a}, dummy);
    spi_byte(d, dummy);
    spi_end();
  endtask

  task automatic spi_read(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] c;
    spi_begin();
    spi_byte({1'b0, a}, c);
    spi_byte(8'h00, d);
    spi_end();
  endtask

  task automatic burst(input int n);
    logic [7:0] r;
    spi_begin();
    spi_byte({1'b0, BURST}, r);
    cmd_rx = r;
    for (int k = 0; k < n; k++) begin
      spi_byte(8'h00, r);
      got[k] = r;
    end
    spi_end();
  endtask

  task automatic check_burst(input int f, input string pre);
    string tag;
    burst(NB);
    check($sformatf("%s/R1 command byte MISO", pre), cmd_rx, 8'h00);
    for (int k = 0; k < NB; k++) begin
      if (k == 0 || k == FULL) tag = "R4";
      else if (k >= TOTAL)     tag = "R5";
      else if (k >= FULL)      tag = "R2";
      else                     tag = "R3";
      check($sformatf("%s/%s byte %0d", pre, tag, k), got[k], expb(f, k));
    end
  endtask

  task automatic send_frame(input int f, input int n);
    for (int i = 0; i < n; i++) begin
      pix_valid = 1'b1;
      pix_sof   = (i == 0);
      pix_data  = pix(f, i);
      @(negedge clk);
    end
    pix_valid = 1'b0;
    pix_sof   = 1'b0;
  endtask

  task automatic send_junk(input int n);
    for (int i = 0; i < n; i++) begin
      pix_valid = 1'b1;
      pix_sof   = 1'b0;
      pix_data  = 6'(63 - i);
      @(negedge clk);
    end
    pix_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R12 reset state, R10 ready
    check("R12 miso after reset", miso, 1'b0);
    check("R12 nav_off after reset", nav_off, 1'b0);
    check("R10 pix_ready after reset", pix_ready, 1'b1);
    burst(8);
    for (int k = 0; k < 8; k++)
      check($sformatf("R12 burst before any capture byte %0d", k), got[k], 8'h00);

    // R9 reads of other addresses, R1 framing
    spi_read(OTHER, rd);
    check("R9 read of other address", rd, 8'h00);
    spi_read(CAP, rd);
    check("R9 read of capture address", rd, 8'h00);
    spi_write(OTHER, 8'hA5);
    check("R9 write to other address leaves nav_off", nav_off, 1'b0);
    check("R1 miso idle with ncs high", miso, 1'b0);

    // R8 arm, R6 burst before fill
    spi_write(CAP, 8'h00);
    check("R8 nav_off set by capture write", nav_off, 1'b1);
    burst(4);
    for (int k = 0; k < 4; k++)
      check($sformatf("R6 burst while armed byte %0d", k), got[k], 8'h00);

    // R2 junk dropped before start of frame, then capture
    send_junk(10);
    send_frame(1, FULL);
    send_frame(2, FULL);
    send_frame(3, FULL);
    check("R10 pix_ready during stream", pix_ready, 1'b1);
    check_burst(1, "R2");

    // R10 later beats do not disturb capture
    send_frame(5, FULL);
    send_frame(6, FULL);
    check_burst(1, "R10");

    // R7 abort after a few bytes, restart from index 0
    burst(5);
    for (int k = 0; k < 5; k++)
      check($sformatf("R7 aborted burst byte %0d", k), got[k], expb(1, k));
    check_burst(1, "R7");

    // R9 write to other address keeps capture
    spi_write(OTHER, 8'h3C);
    check_burst(1, "R9");
    check("R8 nav_off stays set", nav_off, 1'b1);

    // R6 burst decoded before the capture completes stays zero
    spi_write(CAP, 8'h00);
    fork
      burst(NB);
      begin
        repeat (200) @(negedge clk);
        send_frame(7, FULL);
        send_frame(8, FULL);
      end
    join
    for (int k = 0; k < NB; k++)
      check($sformatf("R6 burst spanning completion byte %0d", k), got[k], 8'h00);
    check_burst(7, "R6");

    // R11 rearm while fill consumes a beat every cycle
    spi_write(CAP, 8'h00);
    fork
      begin
        send_frame(20, FULL);
        send_frame(21, FULL);
      end
      spi_write(CAP, 8'h00);
    join
    repeat (10) @(negedge clk);
    send_frame(22, FULL);
    send_frame(23, FULL);
    check_burst(22, "R11");
    check("R8 nav_off after rearm", nav_off, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule